// File: doc/BRIEF.md
# Stack Pointer Bounds Guard

This block owns the system stack pointer for a small processor core. It also watches that pointer against two programmable limits. The stack sits in on-chip RAM and grows toward lower addresses. Each push moves the pointer down by one 16-bit word, and each pop moves it back up by one word.

Every push and every pop compares the resulting pointer with the limits, with no separate check instruction. A push that lands below the low limit raises a sticky overflow flag. A pop that lands above the high limit raises a sticky underflow flag. The trap logic of the core picks up these flags and clears them once it has dealt with the violation.

Software can reload the pointer and either limit through write strobes. All three registers are kept word aligned. The default limits bound a stack of `STACK_BYTES` (2048) bytes that sits just below the reset pointer.

Top module: `stk_guard`

## Requirements
- R1: After reset the pointer reads 16'hFC00 (`SP_RESET`) and all three trap flags are 0. The low limit resets to `SP_RESET - STACK_BYTES` (16'hF400) and the high limit resets to `SP_RESET`.
- R2: A push alone (pushEn=1, popEn=0, spWrEn=0) lowers the pointer by 2 at the next clock edge, wrapping modulo 2^ADDR_W.
- R3: A pop alone raises the pointer by 2 at the next clock edge.
- R4: A push whose resulting pointer is strictly below the low limit currently held sets ovfTrap at the same edge; a result equal to the limit does not. A limit write takes effect from the following cycle.
- R5: A pop whose resulting pointer is strictly above the high limit sets unfTrap at the same edge; a result equal to the limit does not.
- R6: Trap flags stay set until trapClr is asserted. If a new violation arrives in the same cycle as trapClr, the flag stays set.
- R7: pushEn and popEn asserted together set errTrap, leave the pointer unchanged and set neither ovfTrap nor unfTrap.
- R8: Writes to the pointer and to either limit store the value with bit 0 forced to 0. For example, writing 16'h1235 to the pointer reads back 16'h1234, and a low-limit write of 16'hF401 holds 16'hF400.
- R9: A pointer write (spWrEn) takes priority over push and pop in the same cycle. In that cycle the strobes are ignored and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushEn | input | 1 | Push strobe |
| popEn | input | 1 | Pop strobe |
| spWrEn | input | 1 | Pointer load strobe |
| spWrData | input | ADDR_W | Pointer load value |
| ovfLimWrEn | input | 1 | Low-limit write strobe |
| ovfLimWrData | input | ADDR_W | Low-limit write value |
| unfLimWrEn | input | 1 | High-limit write strobe |
| unfLimWrData | input | ADDR_W | High-limit write value |
| trapClr | input | 1 | Clear all trap flags |
| sp | output | ADDR_W | Current stack pointer |
| ovfTrap | output | 1 | Sticky overflow flag |
| unfTrap | output | 1 | Sticky underflow flag |
| errTrap | output | 1 | Sticky push/pop collision flag |

## Verification
The assertions assume that the strobes are sampled only after reset has been released. They also assume that a pointer load may coincide with push or pop, and they qualify their step checks on spWrEn being low. The bench drives every strobe on the falling edge and holds it for one clock only, so no two scenarios overlap. Each scenario starts by loading an explicit pointer, so wrap and limit corners are reached directly instead of by long push sequences.

// File: rtl/stk_guard_pkg.sv
package stk_guard_pkg;
  typedef struct packed {
    logic load;
    logic push;
    logic pop;
    logic collide;
  } stkStrobe_t;
endpackage

// File: rtl/stk_guard_ctrl.sv
module stk_guard_ctrl
  import stk_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushEn,
  input  logic       popEn,
  input  logic       spWrEn,
  input  logic       trapClr,
  input  logic       pushBelow,
  input  logic       popAbove,
  output stkStrobe_t strobe,
  output logic       ovfTrap,
  output logic       unfTrap,
  output logic       errTrap
);
  logic ovfSet, unfSet, errSet;

  always_comb begin
    strobe.load    = spWrEn;
    strobe.collide = !spWrEn && pushEn && popEn;
    strobe.push    = !spWrEn && pushEn && !popEn;
    strobe.pop     = !spWrEn && popEn && !pushEn;
    ovfSet = strobe.push && pushBelow;
    unfSet = strobe.pop && popAbove;
    errSet = strobe.collide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfTrap <= 1'b0;
      unfTrap <= 1'b0;
      errTrap <= 1'b0;
    end else begin
      ovfTrap <= ovfSet | (ovfTrap & ~trapClr);
      unfTrap <= unfSet | (unfTrap & ~trapClr);
      errTrap <= errSet | (errTrap & ~trapClr);
    end
  end
endmodule

// File: rtl/stk_guard_dpath.sv
module stk_guard_dpath
  import stk_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SP_INIT  = 16'hFC00,
  parameter logic [ADDR_W-1:0] OVF_INIT = 16'hF400,
  parameter logic [ADDR_W-1:0] UNF_INIT = 16'hFC00
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkStrobe_t        strobe,
  input  logic [ADDR_W-1:0] spWrData,
  input  logic              ovfLimWrEn,
  input  logic [ADDR_W-1:0] ovfLimWrData,
  input  logic              unfLimWrEn,
  input  logic [ADDR_W-1:0] unfLimWrData,
  output logic [ADDR_W-1:0] sp,
  output logic              pushBelow,
  output logic              popAbove
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] ovfLim, unfLim, spDown, spUp;

  assign spDown    = sp - WORD_STEP;
  assign spUp      = sp + WORD_STEP;
  assign pushBelow = spDown < ovfLim;
  assign popAbove  = spUp > unfLim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp <= SP_INIT & ALIGN_MASK;
    end else if (strobe.load) begin
      sp <= spWrData & ALIGN_MASK;
    end else if (strobe.push) begin
      sp <= spDown;
    end else if (strobe.pop) begin
      sp <= spUp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfLim <= OVF_INIT & ALIGN_MASK;
      unfLim <= UNF_INIT & ALIGN_MASK;
    end else begin
      if (ovfLimWrEn) ovfLim <= ovfLimWrData & ALIGN_MASK;
      if (unfLimWrEn) unfLim <= unfLimWrData & ALIGN_MASK;
    end
  end
endmodule

// File: rtl/stk_guard.sv
module stk_guard
  import stk_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STACK_BYTES = 2048,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'hFC00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic              popEn,
  input  logic              spWrEn,
  input  logic [ADDR_W-1:0] spWrData,
  input  logic              ovfLimWrEn,
  input  logic [ADDR_W-1:0] ovfLimWrData,
  input  logic              unfLimWrEn,
  input  logic [ADDR_W-1:0] unfLimWrData,
  input  logic              trapClr,
  output logic [ADDR_W-1:0] sp,
  output logic              ovfTrap,
  output logic              unfTrap,
  output logic              errTrap
);
  localparam logic [ADDR_W-1:0] OVF_RESET = SP_RESET - ADDR_W'(STACK_BYTES);

  stkStrobe_t strobe;
  logic pushBelow, popAbove;

  stk_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .spWrEn(spWrEn), .trapClr(trapClr), .pushBelow(pushBelow),
    .popAbove(popAbove), .strobe(strobe), .ovfTrap(ovfTrap),
    .unfTrap(unfTrap), .errTrap(errTrap)
  );

  stk_guard_dpath #(
    .ADDR_W(ADDR_W), .SP_INIT(SP_RESET), .OVF_INIT(OVF_RESET),
    .UNF_INIT(SP_RESET)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spWrData(spWrData),
    .ovfLimWrEn(ovfLimWrEn), .ovfLimWrData(ovfLimWrData),
    .unfLimWrEn(unfLimWrEn), .unfLimWrData(unfLimWrData),
    .sp(sp), .pushBelow(pushBelow), .popAbove(popAbove)
  );
endmodule

// File: rtl/stk_guard_chk.sv
module stk_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushEn,
  input logic              popEn,
  input logic              spWrEn,
  input logic              trapClr,
  input logic [ADDR_W-1:0] sp,
  input logic              ovfTrap,
  input logic              unfTrap,
  input logic              errTrap
);
  AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |-> sp[0] == 1'b0); // R8
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && !spWrEn) |=> sp == $past(sp) - ADDR_W'(2)); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && !spWrEn) |=> sp == $past(sp) + ADDR_W'(2)); // R3
  AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn && !spWrEn) |=> ($stable(sp) && errTrap)); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfTrap) |-> ($past(pushEn) && !$past(popEn) && !$past(spWrEn))); // R4
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unfTrap) |-> ($past(popEn) && !$past(pushEn) && !$past(spWrEn))); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap && !trapClr) |=> ovfTrap); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (trapClr && !pushEn && !popEn) |=> (!ovfTrap && !unfTrap && !errTrap)); // R6
endmodule

bind stk_guard stk_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
  .spWrEn(spWrEn), .trapClr(trapClr), .sp(sp), .ovfTrap(ovfTrap),
  .unfTrap(unfTrap), .errTrap(errTrap)
);

// File: tb/stk_guard_bench.sv
`timescale 1ns/1ps
module stk_guard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushEn = 0, popEn = 0, spWrEn = 0, ovfLimWrEn = 0, unfLimWrEn = 0, trapClr = 0;
  logic [15:0] spWrData = '0, ovfLimWrData = '0, unfLimWrData = '0;
  logic [15:0] sp;
  logic ovfTrap, unfTrap, errTrap;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stk_guard u_stk_guard (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn), .spWrEn(spWrEn),
    .spWrData(spWrData), .ovfLimWrEn(ovfLimWrEn), .ovfLimWrData(ovfLimWrData),
    .unfLimWrEn(unfLimWrEn), .unfLimWrData(unfLimWrData), .trapClr(trapClr),
    .sp(sp), .ovfTrap(ovfTrap), .unfTrap(unfTrap), .errTrap(errTrap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    pushEn = 0; popEn = 0; spWrEn = 0; ovfLimWrEn = 0; unfLimWrEn = 0; trapClr = 0;
  endtask

  task automatic loadSp(input logic [15:0] v);
    spWrEn = 1; spWrData = v; tick();
  endtask

  task automatic clearAll();
    trapClr = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 sp", 32'(sp), 32'hFC00);
    chk("R1 flags", {ovfTrap, unfTrap, errTrap}, 0);
  endtask

  task automatic t_push_pop();
    repeat (3) begin pushEn = 1; tick(); end
    chk("R2 push x3", 32'(sp), 32'hFBFA);
    popEn = 1; tick();
    chk("R3 pop", 32'(sp), 32'hFBFC);
    chk("R4 R5 no flags", {ovfTrap, unfTrap}, 0);
    loadSp(16'h0000); pushEn = 1; tick();
    chk("R2 wrap", 32'(sp), 32'hFFFE);
    chk("R4 no ovf on wrap", 32'(ovfTrap), 0);
  endtask

  task automatic t_underflow();
    loadSp(16'hFBFE); popEn = 1; tick();
    chk("R5 equal no trap", 32'(unfTrap), 0);
    popEn = 1; tick();
    chk("R5 above trap", 32'(unfTrap), 1);
    tick();
    chk("R6 sticky", 32'(unfTrap), 1);
    clearAll();
    chk("R6 cleared", 32'(unfTrap), 0);
  endtask

  task automatic t_overflow();
    loadSp(16'hF402); pushEn = 1; tick();
    chk("R4 equal no trap", 32'(ovfTrap), 0);
    pushEn = 1; tick();
    chk("R4 below trap", 32'(ovfTrap), 1);
    pushEn = 1; trapClr = 1; tick();
    chk("R6 set wins", 32'(ovfTrap), 1);
    clearAll();
    ovfLimWrEn = 1; ovfLimWrData = 16'h8000; tick();
    loadSp(16'h8000); pushEn = 1; tick();
    chk("R4 new limit", 32'(ovfTrap), 1);
    clearAll();
  endtask

  task automatic t_collide();
    loadSp(16'h7000);
    pushEn = 1; popEn = 1; tick();
    chk("R7 err", 32'(errTrap), 1);
    chk("R7 sp held", 32'(sp), 32'h7000);
    chk("R7 no ovf", {ovfTrap, unfTrap}, 0);
    clearAll();
  endtask

  task automatic t_priority();
    loadSp(16'h8002);
    spWrEn = 1; spWrData = 16'h7000; pushEn = 1; tick();
    chk("R9 load wins", 32'(sp), 32'h7000);
    chk("R9 no trap", {ovfTrap, unfTrap, errTrap}, 0);
  endtask

  task automatic t_align();
    loadSp(16'h1235);
    chk("R8 sp align", 32'(sp), 32'h1234);
    ovfLimWrEn = 1; ovfLimWrData = 16'hF401; tick();
    loadSp(16'hF402); pushEn = 1; tick();
    chk("R8 limit align", 32'(ovfTrap), 0);
    chk("R8 sp", 32'(sp), 32'hF400);
  endtask

  initial begin
    #50000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_push_pop();
    t_underflow();
    t_overflow();
    t_collide();
    t_priority();
    t_align();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule